// File: doc/BRIEF.md
# Dual-Processor Doorbell Mailbox

This block keeps two 64-bit doorbell mailboxes, one for each of two processors. Any agent on the internal register port can read either mailbox, set bits in it with a write-one-to-set location, or drop bits with a write-one-to-clear location. A writer never needs a read-modify-write sequence, and the hardware does not check who owns a mailbox. A second, restricted port stands for an external-bus window with one 4 KB page per mailbox. Through that window an agent can read a mailbox or set bits in it, but it can never clear any bit.

Each mailbox drives four interrupt lines, one for each 16-bit quarter. A line is high while any bit of its quarter is set. Mailbox 0 drives only the interrupt outputs of processor 0, and mailbox 1 drives only those of processor 1. Software can treat the mailbox as 64 separate event flags or as four 16-bit message slots.

Top module: `doorbell_mbox_unit`

## Requirements
- R1: After a synchronous reset both mailboxes read as zero and all eight interrupt outputs are low.
- R2: A write to a set location ORs the write data into the selected mailbox. A 1 sets the matching bit and a 0 leaves its bit unchanged.
- R3: A write to the full-port clear location clears every mailbox bit where the data has a 1 and leaves the other bits unchanged.
- R4: Interrupt bit k of a mailbox is high exactly when that mailbox has any bit set in [16k+15:16k], so bit 0 covers 15:0 and bit 3 covers 63:48.
- R5: On the full port, address bit 13 selects the mailbox, and within each page offset 0x0C0 reads, 0x0C8 sets and 0x0D0 clears. Mailbox 0 is at 0x00C0 and mailbox 1 at 0x20C0. Read data and a valid strobe appear one cycle after a read request. Reading the set or clear location returns zero.
- R6: On the alias port, address bit 13 selects the mailbox and bit 12 must be 1, so the pages are 0x1000 and 0x3000. In a page, any address with low nibble 0x0 reads the mailbox and any address with low nibble 0x8 sets bits. Other addresses read zero and ignore writes.
- R7: No alias-port write ever clears a mailbox bit, including writes to the read address.
- R8: The full port can set and clear both mailboxes, with no ownership check.
- R9: Mailbox 0 drives only irq_cpu0 and mailbox 1 drives only irq_cpu1.
- R10: Set masks arriving from both ports in the same cycle are ORed. If a set and a clear hit the same bit in the same cycle, the bit ends up set.
- R11: Interrupt outputs are registered. A line rises one cycle after the clock edge that stores the setting write, and falls one cycle after the edge that stores the clear that empties its quarter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fa_req | input | 1 | Full-access port request |
| fa_we | input | 1 | Full-access port write enable |
| fa_addr | input | 14 | Full-access port byte address |
| fa_wdata | input | 64 | Full-access port write data |
| fa_rdata | output | 64 | Full-access port read data, registered |
| fa_rvalid | output | 1 | Full-access port read data valid |
| al_req | input | 1 | Alias port request |
| al_we | input | 1 | Alias port write enable |
| al_addr | input | 14 | Alias port byte address |
| al_wdata | input | 64 | Alias port write data |
| al_rdata | output | 64 | Alias port read data, registered |
| al_rvalid | output | 1 | Alias port read data valid |
| irq_cpu0 | output | 4 | Quarter interrupts of mailbox 0 |
| irq_cpu1 | output | 4 | Quarter interrupts of mailbox 1 |

## Verification
The bench uses the default parameters: a 64-bit mailbox split into four 16-bit quarters and a 14-bit address. At this size both pages and both alias pages are reachable, and bits in every quarter, including the top and bottom bits, can be set. Addresses in the alias pages with varied middle bits show that only bit 13, bit 12 and the low nibble are decoded. Directed cycles drive both ports at once to cover the case where a set meets a clear on the same bit, and the bench samples the interrupt lines in the cycle before and the cycle after they should change.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_READ = 2'd1,
    OP_SET  = 2'd2,
    OP_CLR  = 2'd3
  } mbox_op_t;

  localparam logic [11:0] OFS_READ = 12'h0C0;
  localparam logic [11:0] OFS_SET  = 12'h0C8;
  localparam logic [11:0] OFS_CLR  = 12'h0D0;

  localparam logic [3:0] NIB_READ = 4'h0;
  localparam logic [3:0] NIB_SET  = 4'h8;
endpackage

// File: rtl/mbox_full_decode.sv
module mbox_full_decode
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output logic              mbox_sel,
  output mbox_op_t          op
);
  localparam int OFS_W = ADDR_W - 1;

  logic [OFS_W-1:0] ofs;

  assign mbox_sel = addr[ADDR_W-1];
  assign ofs      = addr[OFS_W-1:0];

  always_comb begin
    op = OP_NONE;
    if (req) begin
      if (!we) begin
        op = OP_READ;
        if (ofs != OFS_W'(OFS_READ)) op = OP_NONE;
      end else if (ofs == OFS_W'(OFS_SET)) begin
        op = OP_SET;
      end else if (ofs == OFS_W'(OFS_CLR)) begin
        op = OP_CLR;
      end
    end
  end
endmodule

// File: rtl/mbox_alias_decode.sv
module mbox_alias_decode
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output logic              mbox_sel,
  output mbox_op_t          op
);
  logic in_page;
  logic [3:0] nib;

  assign mbox_sel = addr[ADDR_W-1];
  assign in_page  = addr[ADDR_W-2];
  assign nib      = addr[3:0];

  always_comb begin
    op = OP_NONE;
    if (req && in_page) begin
      if (!we && nib == NIB_READ) op = OP_READ;
      else if (we && nib == NIB_SET) op = OP_SET;
    end
  end
endmodule

// File: rtl/mbox_cell.sv
module mbox_cell #(
  parameter int MBOX_W = 64,
  parameter int QTR_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [MBOX_W-1:0]        set_mask,
  input  logic [MBOX_W-1:0]        clr_mask,
  output logic [MBOX_W-1:0]        mbox_q,
  output logic [MBOX_W/QTR_W-1:0]  irq_q
);
  localparam int N_Q = MBOX_W / QTR_W;

  logic [MBOX_W-1:0] mbox_d;
  logic [N_Q-1:0]    qtr_any;

  // Set is applied after clear so a simultaneous set wins.
  assign mbox_d = (mbox_q & ~clr_mask) | set_mask;

  always_ff @(posedge clk) begin
    if (rst) mbox_q <= '0;
    else     mbox_q <= mbox_d;
  end

  for (genvar k = 0; k < N_Q; k++) begin : g_qtr
    assign qtr_any[k] = |mbox_q[k*QTR_W +: QTR_W];

    AST_IRQ_QUARTER: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (irq_q[k] == (|$past(mbox_q[k*QTR_W +: QTR_W])))); // R4
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= '0;
    else     irq_q <= qtr_any;
  end

  AST_SET_LANDS: assert property (@(posedge clk) disable iff (rst)
    (set_mask != '0) |=> ((mbox_q & $past(set_mask)) == $past(set_mask))); // R2

  AST_CLR_LANDS: assert property (@(posedge clk) disable iff (rst)
    ((clr_mask & ~set_mask) != '0) |=> ((mbox_q & $past(clr_mask & ~set_mask)) == '0)); // R3

  AST_NO_CLR_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (clr_mask == '0) |=> ((mbox_q & $past(mbox_q)) == $past(mbox_q))); // R7
endmodule

// File: rtl/doorbell_mbox_unit.sv
module doorbell_mbox_unit
  import mbox_pkg::*;
#(
  parameter int MBOX_W = 64,
  parameter int QTR_W  = 16,
  parameter int ADDR_W = 14
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    fa_req,
  input  logic                    fa_we,
  input  logic [ADDR_W-1:0]       fa_addr,
  input  logic [MBOX_W-1:0]       fa_wdata,
  output logic [MBOX_W-1:0]       fa_rdata,
  output logic                    fa_rvalid,
  input  logic                    al_req,
  input  logic                    al_we,
  input  logic [ADDR_W-1:0]       al_addr,
  input  logic [MBOX_W-1:0]       al_wdata,
  output logic [MBOX_W-1:0]       al_rdata,
  output logic                    al_rvalid,
  output logic [MBOX_W/QTR_W-1:0] irq_cpu0,
  output logic [MBOX_W/QTR_W-1:0] irq_cpu1
);
  localparam int N_Q    = MBOX_W / QTR_W;
  localparam int N_MBOX = 2;

  logic     fa_sel, al_sel;
  mbox_op_t fa_op, al_op;

  logic [MBOX_W-1:0] state   [N_MBOX];
  logic [N_Q-1:0]    irq_all [N_MBOX];

  mbox_full_decode #(.ADDR_W(ADDR_W)) u_fa_dec (
    .req(fa_req), .we(fa_we), .addr(fa_addr), .mbox_sel(fa_sel), .op(fa_op)
  );

  mbox_alias_decode #(.ADDR_W(ADDR_W)) u_al_dec (
    .req(al_req), .we(al_we), .addr(al_addr), .mbox_sel(al_sel), .op(al_op)
  );

  for (genvar m = 0; m < N_MBOX; m++) begin : g_mbox
    logic [MBOX_W-1:0] set_m, clr_m;
    logic              fa_hit, al_hit;

    assign fa_hit = (fa_sel == 1'(m));
    assign al_hit = (al_sel == 1'(m));

    // Alias port contributes only to the set mask: it cannot clear.
    assign set_m = ((fa_hit && fa_op == OP_SET) ? fa_wdata : '0)
                 | ((al_hit && al_op == OP_SET) ? al_wdata : '0);
    assign clr_m = (fa_hit && fa_op == OP_CLR) ? fa_wdata : '0;

    mbox_cell #(.MBOX_W(MBOX_W), .QTR_W(QTR_W)) u_cell (
      .clk(clk), .rst(rst),
      .set_mask(set_m), .clr_mask(clr_m),
      .mbox_q(state[m]), .irq_q(irq_all[m])
    );
  end

  assign irq_cpu0 = irq_all[0];
  assign irq_cpu1 = irq_all[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      fa_rdata  <= '0;
      fa_rvalid <= 1'b0;
      al_rdata  <= '0;
      al_rvalid <= 1'b0;
    end else begin
      fa_rvalid <= fa_req && !fa_we;
      al_rvalid <= al_req && !al_we;
      fa_rdata  <= (fa_op == OP_READ) ? state[fa_sel] : '0;
      al_rdata  <= (al_op == OP_READ) ? state[al_sel] : '0;
    end
  end

  AST_FA_RVALID: assert property (@(posedge clk) disable iff (rst)
    (fa_req && !fa_we) |=> fa_rvalid); // R5

  AST_AL_RVALID: assert property (@(posedge clk) disable iff (rst)
    (al_req && !al_we) |=> al_rvalid); // R6

  AST_NO_CROSS_ROUTE: assert property (@(posedge clk) disable iff (rst)
    (state[0] == '0) |=> (irq_cpu0 == '0)); // R9
endmodule

// File: tb/test_doorbell_mbox_unit.sv
module test_doorbell_mbox_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        fa_req, fa_we, al_req, al_we;
  logic [13:0] fa_addr, al_addr;
  logic [63:0] fa_wdata, al_wdata, fa_rdata, al_rdata;
  logic        fa_rvalid, al_rvalid;
  logic [3:0]  irq_cpu0, irq_cpu1;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  always #10 clk = ~clk;

  doorbell_mbox_unit i_doorbell_mbox_unit (
    .clk(clk), .rst(rst),
    .fa_req(fa_req), .fa_we(fa_we), .fa_addr(fa_addr), .fa_wdata(fa_wdata),
    .fa_rdata(fa_rdata), .fa_rvalid(fa_rvalid),
    .al_req(al_req), .al_we(al_we), .al_addr(al_addr), .al_wdata(al_wdata),
    .al_rdata(al_rdata), .al_rvalid(al_rvalid),
    .irq_cpu0(irq_cpu0), .irq_cpu1(irq_cpu1)
  );

  // {req tag[159:156], port[155] (1=alias), we[154], addr[153:140],
  //  data[139:76], exp_rdata[75:12], exp_irq0[11:8], exp_irq1[7:4], pad[3:0]}
  localparam int NV = 16;
  localparam logic [159:0] VEC [NV] = '{
    {4'd1, 1'b0, 1'b0, 14'h00C0, 64'h0, 64'h0, 4'h0, 4'h0, 4'h0},                                    // R1 reads zero
    {4'd2, 1'b0, 1'b1, 14'h00C8, 64'h0000_0000_0000_0001, 64'h0, 4'h1, 4'h0, 4'h0},                  // R2 bit 0
    {4'd4, 1'b0, 1'b1, 14'h00C8, 64'h8000_0000_0000_0000, 64'h0, 4'h9, 4'h0, 4'h0},                  // R4 top quarter
    {4'd5, 1'b0, 1'b0, 14'h00C0, 64'h0, 64'h8000_0000_0000_0001, 4'h9, 4'h0, 4'h0},                  // R5 read
    {4'd5, 1'b0, 1'b0, 14'h00C8, 64'h0, 64'h0, 4'h9, 4'h0, 4'h0},                                    // R5 set loc reads 0
    {4'd3, 1'b0, 1'b1, 14'h00D0, 64'h0000_0000_0000_0001, 64'h0, 4'h8, 4'h0, 4'h0},                  // R3 clear
    {4'd6, 1'b1, 1'b1, 14'h3A48, 64'h0000_FFFF_0000_0000, 64'h0, 4'h8, 4'h4, 4'h0},                  // R6 alias set mbox1
    {4'd6, 1'b1, 1'b0, 14'h3120, 64'h0, 64'h0000_FFFF_0000_0000, 4'h8, 4'h4, 4'h0},                  // R6 alias read
    {4'd7, 1'b1, 1'b1, 14'h1000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 4'h8, 4'h4, 4'h0},                  // R7 write to read nibble
    {4'd7, 1'b0, 1'b0, 14'h00C0, 64'h0, 64'h8000_0000_0000_0000, 4'h8, 4'h4, 4'h0},                  // R7 unchanged
    {4'd8, 1'b0, 1'b1, 14'h20D0, 64'h0000_0001_0000_0000, 64'h0, 4'h8, 4'h4, 4'h0},                  // R8 clear mbox1
    {4'd9, 1'b0, 1'b1, 14'h20D0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 4'h8, 4'h0, 4'h0},                  // R9 irq1 only
    {4'd6, 1'b1, 1'b1, 14'h1008, 64'h0000_0000_00F0_0000, 64'h0, 4'hA, 4'h0, 4'h0},                  // R6 alias set mbox0
    {4'd6, 1'b1, 1'b0, 14'h1FF0, 64'h0, 64'h8000_0000_00F0_0000, 4'hA, 4'h0, 4'h0},                  // R6 any addr nibble 0
    {4'd6, 1'b1, 1'b1, 14'h0008, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 4'hA, 4'h0, 4'h0},                  // R6 outside page
    {4'd6, 1'b1, 1'b0, 14'h1004, 64'h0, 64'h0, 4'hA, 4'h0, 4'h0}                                     // R6 other nibble reads 0
  };

  task automatic check(input int tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL R%0d %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic fa_op(input logic we, input logic [13:0] a, input logic [63:0] d);
    @(negedge clk);
    fa_req = 1'b1; fa_we = we; fa_addr = a; fa_wdata = d;
    @(negedge clk);
    fa_req = 1'b0; fa_we = 1'b0;
  endtask

  task automatic al_op(input logic we, input logic [13:0] a, input logic [63:0] d);
    @(negedge clk);
    al_req = 1'b1; al_we = we; al_addr = a; al_wdata = d;
    @(negedge clk);
    al_req = 1'b0; al_we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    fa_req = 0; fa_we = 0; fa_addr = '0; fa_wdata = '0;
    al_req = 0; al_we = 0; al_addr = '0; al_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(1, "irq0 after reset", {60'd0, irq_cpu0}, 64'd0); // R1
    check(1, "irq1 after reset", {60'd0, irq_cpu1}, 64'd0); // R1

    for (int i = 0; i < NV; i++) begin
      logic [159:0] v;
      v = VEC[i];
      if (v[155]) al_op(v[154], v[153:140], v[139:76]);
      else        fa_op(v[154], v[153:140], v[139:76]);
      if (!v[154]) begin
        if (v[155]) begin
          check(int'(v[159:156]), "alias rdata", al_rdata, v[75:12]);
          check(int'(v[159:156]), "alias rvalid", {63'd0, al_rvalid}, 64'd1);
        end else begin
          check(int'(v[159:156]), "full rdata", fa_rdata, v[75:12]);
          check(int'(v[159:156]), "full rvalid", {63'd0, fa_rvalid}, 64'd1);
        end
      end
      @(negedge clk);
      check(int'(v[159:156]), "irq_cpu0", {60'd0, irq_cpu0}, {60'd0, v[11:8]});
      check(int'(v[159:156]), "irq_cpu1", {60'd0, irq_cpu1}, {60'd0, v[7:4]});
    end

    // R11: irq registered one cycle after the stored write
    fa_op(1'b1, 14'h20C8, 64'h1);
    check(11, "irq1 before rise", {60'd0, irq_cpu1}, 64'h0);
    @(negedge clk);
    check(11, "irq1 after rise", {60'd0, irq_cpu1}, 64'h1);
    fa_op(1'b1, 14'h20D0, 64'h1);
    check(11, "irq1 before fall", {60'd0, irq_cpu1}, 64'h1);
    @(negedge clk);
    check(11, "irq1 after fall", {60'd0, irq_cpu1}, 64'h0);

    // R10: alias set and full clear on same bit in one cycle -> set wins
    @(negedge clk);
    fa_req = 1; fa_we = 1; fa_addr = 14'h00D0; fa_wdata = 64'h20;
    al_req = 1; al_we = 1; al_addr = 14'h1008; al_wdata = 64'h20;
    @(negedge clk);
    fa_req = 0; al_req = 0; fa_we = 0; al_we = 0;
    fa_op(1'b0, 14'h00C0, 64'h0);
    check(10, "set beats clear", fa_rdata, 64'h8000_0000_00F0_0020);

    // R10: sets from both ports OR together
    @(negedge clk);
    fa_req = 1; fa_we = 1; fa_addr = 14'h20C8; fa_wdata = 64'h4;
    al_req = 1; al_we = 1; al_addr = 14'h3008; al_wdata = 64'h8;
    @(negedge clk);
    fa_req = 0; al_req = 0; fa_we = 0; al_we = 0;
    al_op(1'b0, 14'h3000, 64'h0);
    check(10, "dual set OR", al_rdata, 64'hC);

    // R1: mid-run reset empties both mailboxes
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(1, "irq0 after reset", {60'd0, irq_cpu0}, 64'h0);
    check(1, "irq1 after reset", {60'd0, irq_cpu1}, 64'h0);
    fa_op(1'b0, 14'h00C0, 64'h0);
    check(1, "mbox0 after reset", fa_rdata, 64'h0);
    fa_op(1'b0, 14'h20C0, 64'h0);
    check(1, "mbox1 after reset", fa_rdata, 64'h0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule